// File: doc/BRIEF.md
# Sleeping UART Receiver with Automatic Wake-Up

This block receives asynchronous serial characters on a shared multidrop line and lets a node sleep through traffic that is not meant for it. Every bit time the bit-rate logic pulses `bit_tick` and presents three samples of the line taken near the bit centre. A majority vote decides the bit, and any disagreement among the samples marks the character as noisy. A frame is a zero start bit, then 8 or 9 data bits with the least significant bit first, then one stop bit.

Software can set a sleep bit. While the bit is set, no receive status flag may rise. The hardware clears the bit by one of two methods, chosen by `wake_addr`. With the idle-line method, it counts consecutive ones received since the sleep bit was set. With the address-mark method, it waits for a character whose top data bit is set. Flags that were set before sleep began are left as they are. Disabling the receiver forces all flags low.

Top module: `uart_wk_rx`

## Requirements
- R1: A frame is a 0 start bit, then 8 data bits (`word9`=0) or 9 data bits (`word9`=1) sent least significant bit first, then a stop bit. When the stop bit is sampled, the data bits are written to `rx_data` (bit 0 holds the first data bit, and bit 8 is 0 in 8-bit mode) and `flag_rdrf` is set.
- R2: Each bit is the majority of the three `rx_smp` samples. If the samples disagree at any bit of a frame, from start to stop, `flag_noise` is set for that character. A stop bit sampled as 0 sets `flag_ferr`.
- R3: While `rx_en` is 0, all five flags (`flag_rdrf`, `flag_idle`, `flag_ovr`, `flag_noise`, `flag_ferr`) read 0 and none of them can be set.
- R4: While `sleep` is 1, no flag goes from 0 to 1. The only exception is the waking character of R8. Characters received in idle-line mode while asleep leave `rx_data` unchanged.
- R5: A write of 1 to the sleep bit leaves every flag that is already set unchanged.
- R6: In idle-line mode (`wake_addr`=0), `sleep` clears once a run of consecutive 1 bits reaches 10 (8-bit mode) or 11 (9-bit mode). The run is counted from 0 when the sleep bit is set, and any received 0 resets it to zero.
- R7: In idle-line mode, a write of 1 to the sleep bit is ignored while the line is idle, meaning the current run of ones has already reached the frame length.
- R8: In address-mark mode (`wake_addr`=1), a write of 1 to the sleep bit is always accepted. A character received while asleep with its address bit set (bit 7 in 8-bit mode, bit 8 in 9-bit mode) clears `sleep`, is stored in `rx_data` and sets `flag_rdrf`. A character with the address bit clear is dropped, and neither the data nor any flag changes.
- R9: If a character completes while `flag_rdrf` is already set, `flag_ovr` is set and `rx_data` keeps the older character.
- R10: While awake, `flag_idle` is set when a run of ones reaches the frame length after at least one 0 has been received since the previous idle detection.
- R11: A one-cycle pulse on `flag_clr` clears all five flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable |
| word9 | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| wake_addr | input | 1 | 1 selects address-mark wake, 0 selects idle-line wake |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_smp | input | SAMPLES | Line samples for the current bit |
| sleep_we | input | 1 | Write strobe for the sleep bit |
| sleep_wd | input | 1 | Value written to the sleep bit |
| flag_clr | input | 1 | Clears all status flags |
| rx_data | output | 9 | Received data register |
| flag_rdrf | output | 1 | Receive data register full |
| flag_idle | output | 1 | Idle line detected |
| flag_ovr | output | 1 | Overrun |
| flag_noise | output | 1 | Noise seen in the last stored character |
| flag_ferr | output | 1 | Framing error in the last stored character |
| sleep | output | 1 | Sleep bit as read back |

## Verification
The run counter is the main target. The bench places a zero-filled character in the middle of a run of ones, so a design that failed to reset the count on a zero would wake early. It then checks that waking takes exactly 10 or 11 ones, so an off-by-one error or a word length that was ignored would show up as a sleep bit in the wrong state at the boundary bit. In address-mark mode the bench sends a character with the address bit clear before the real address, in both word lengths. A design that tested the wrong bit position, or let dropped characters through, would wake on the wrong character or change the data register. Sleep writes on an idle line, flags kept across sleep entry, overrun keeping the old data, and forced-low flags while disabled are each checked directly.

// File: rtl/uart_wk_pkg.sv
package uart_wk_pkg;

    localparam int DATA_W = 9;   // widest character
    localparam int RUN_W  = 4;   // ones-run counter width (saturates)
    localparam int BIT_W  = 4;   // data bit index width

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_DATA = 2'd1,
        FS_STOP = 2'd2
    } frame_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              noise;
        logic              ferr;
    } frame_t;

    typedef struct packed {
        logic rdrf;
        logic idle;
        logic ovr;
        logic noise;
        logic ferr;
    } rx_flags_t;

    function automatic logic [RUN_W-1:0] frame_len(input logic nine);
        return nine ? RUN_W'(11) : RUN_W'(10);
    endfunction

    function automatic logic [BIT_W-1:0] data_bits(input logic nine);
        return nine ? BIT_W'(9) : BIT_W'(8);
    endfunction

endpackage

// File: rtl/uart_wk_vote.sv
module uart_wk_vote #(
    parameter int N = 3
) (
    input  logic [N-1:0] smp,
    output logic         bit_val,
    output logic         noisy
);
    always_comb begin
        bit_val = ($countones(smp) > (N / 2));
        noisy   = (smp != '0) && (smp != '1);
    end
endmodule

// File: rtl/uart_wk_framer.sv
module uart_wk_framer
    import uart_wk_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   word9,
    input  logic   tick,
    input  logic   bit_val,
    input  logic   noisy,
    output frame_t frame_q,
    output logic   done_q
);
    frame_state_e      state_q;
    logic [BIT_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              noise_acc_q;
    logic [BIT_W-1:0]  last_idx;

    assign last_idx = data_bits(word9) - BIT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q     <= FS_IDLE;
            idx_q       <= '0;
            shreg_q     <= '0;
            noise_acc_q <= 1'b0;
            done_q      <= 1'b0;
            frame_q     <= '0;
        end else begin
            done_q <= 1'b0;
            if (tick) begin
                case (state_q)
                    FS_IDLE: if (!bit_val) begin
                        state_q     <= FS_DATA;
                        idx_q       <= '0;
                        shreg_q     <= '0;
                        noise_acc_q <= noisy;
                    end
                    FS_DATA: begin
                        shreg_q[idx_q] <= bit_val;
                        noise_acc_q    <= noise_acc_q | noisy;
                        if (idx_q == last_idx) state_q <= FS_STOP;
                        else                   idx_q   <= idx_q + BIT_W'(1);
                    end
                    default: begin
                        frame_q.data  <= shreg_q;
                        frame_q.noise <= noise_acc_q | noisy;
                        frame_q.ferr  <= !bit_val;
                        done_q        <= 1'b1;
                        state_q       <= FS_IDLE;
                    end
                endcase
            end
        end
    end

    // a frame lasts at least ten bit times, so completion is a lone pulse
    assert_done_single_R1: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);
endmodule

// File: rtl/uart_wk_wake.sv
module uart_wk_wake
    import uart_wk_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic word9,
    input  logic wake_addr,
    input  logic tick,
    input  logic bit_val,
    input  logic sleep_we,
    input  logic sleep_wd,
    input  logic char_done,
    input  logic addr_bit,
    output logic sleep_q,
    output logic run_full,
    output logic line_idle
);
    logic [RUN_W-1:0] run_q;
    logic [RUN_W-1:0] flen;
    logic             set_ok;

    always_comb begin
        flen      = frame_len(word9);
        line_idle = (run_q >= flen);
        run_full  = en && tick && bit_val && (run_q == flen - RUN_W'(1));
        set_ok    = sleep_we && sleep_wd && (wake_addr || !line_idle);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            run_q <= '0;
        end else if (set_ok) begin
            run_q <= '0;
        end else if (tick) begin
            if (!bit_val)        run_q <= '0;
            else if (run_q != '1) run_q <= run_q + RUN_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sleep_q <= 1'b0;
        end else if (sleep_we) begin
            if (!sleep_wd)   sleep_q <= 1'b0;
            else if (set_ok) sleep_q <= 1'b1;
        end else if (sleep_q && !wake_addr && run_full) begin
            sleep_q <= 1'b0;
        end else if (sleep_q && wake_addr && char_done && addr_bit) begin
            sleep_q <= 1'b0;
        end
    end

    assert_idle_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (sleep_we && sleep_wd && !wake_addr && !sleep_q && line_idle) |=> !sleep_q);
endmodule

// File: rtl/uart_wk_rx.sv
module uart_wk_rx
    import uart_wk_pkg::*;
#(
    parameter int SAMPLES = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              word9,
    input  logic              wake_addr,
    input  logic              bit_tick,
    input  logic [SAMPLES-1:0] rx_smp,
    input  logic              sleep_we,
    input  logic              sleep_wd,
    input  logic              flag_clr,
    output logic [DATA_W-1:0] rx_data,
    output logic              flag_rdrf,
    output logic              flag_idle,
    output logic              flag_ovr,
    output logic              flag_noise,
    output logic              flag_ferr,
    output logic              sleep
);
    logic      bit_val, noisy, done, addr_bit, run_full, line_idle, accept;
    frame_t    frame;
    rx_flags_t flags_q, flags_d;
    logic [DATA_W-1:0] data_d;
    logic      armed_q, armed_d;

    uart_wk_vote #(.N(SAMPLES)) u_vote (
        .smp(rx_smp), .bit_val(bit_val), .noisy(noisy)
    );

    uart_wk_framer u_framer (
        .clk(clk), .rst(rst), .en(rx_en), .word9(word9), .tick(bit_tick),
        .bit_val(bit_val), .noisy(noisy), .frame_q(frame), .done_q(done)
    );

    assign addr_bit = word9 ? frame.data[DATA_W-1] : frame.data[DATA_W-2];

    uart_wk_wake u_wake (
        .clk(clk), .rst(rst), .en(rx_en), .word9(word9), .wake_addr(wake_addr),
        .tick(bit_tick), .bit_val(bit_val), .sleep_we(sleep_we),
        .sleep_wd(sleep_wd), .char_done(done), .addr_bit(addr_bit),
        .sleep_q(sleep), .run_full(run_full), .line_idle(line_idle)
    );

    assign accept = done && (!sleep || (wake_addr && addr_bit));

    always_comb begin
        flags_d = flags_q;
        data_d  = rx_data;
        armed_d = armed_q;
        if (flag_clr) flags_d = '0;
        if (bit_tick && !bit_val) armed_d = 1'b1;
        if (run_full) armed_d = 1'b0;
        if (accept) begin
            if (flags_q.rdrf) begin
                flags_d.ovr = 1'b1;
            end else begin
                data_d        = frame.data;
                flags_d.rdrf  = 1'b1;
                flags_d.noise = frame.noise;
                flags_d.ferr  = frame.ferr;
            end
        end
        if (run_full && armed_q && !sleep) flags_d.idle = 1'b1;
        if (!rx_en) begin
            flags_d = '0;
            armed_d = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
            rx_data <= '0;
            armed_q <= 1'b0;
        end else begin
            flags_q <= flags_d;
            rx_data <= data_d;
            armed_q <= armed_d;
        end
    end

    assign flag_rdrf  = flags_q.rdrf;
    assign flag_idle  = flags_q.idle;
    assign flag_ovr   = flags_q.ovr;
    assign flag_noise = flags_q.noise;
    assign flag_ferr  = flags_q.ferr;

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (flags_q == '0));

    assert_asleep_no_rise_R4: assert property (@(posedge clk) disable iff (rst)
        (sleep && !(done && wake_addr && addr_bit)) |=>
            ((flags_q & ~$past(flags_q)) == '0));

    assert_sleep_set_keeps_R5: assert property (@(posedge clk) disable iff (rst)
        (sleep_we && sleep_wd && rx_en && !flag_clr && !done && !run_full) |=>
            ((flags_q & $past(flags_q)) == $past(flags_q)));

    assert_overrun_keeps_data_R9: assert property (@(posedge clk) disable iff (rst)
        (accept && flags_q.rdrf && rx_en && !flag_clr) |=>
            (flags_q.ovr && $stable(rx_data)));
endmodule

// File: tb/uart_wk_rx_test.sv
module uart_wk_rx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0, word9 = 1'b0, wake_addr = 1'b0, bit_tick = 1'b0;
    logic [2:0] rx_smp = 3'b111;
    logic       sleep_we = 1'b0, sleep_wd = 1'b0, flag_clr = 1'b0;
    logic [8:0] rx_data;
    logic       flag_rdrf, flag_idle, flag_ovr, flag_noise, flag_ferr, sleep;
    int         checks = 0, errors = 0;
    bit         finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    uart_wk_rx #(.SAMPLES(3)) uut (
        .clk(clk), .rst(rst), .rx_en(rx_en), .word9(word9), .wake_addr(wake_addr),
        .bit_tick(bit_tick), .rx_smp(rx_smp), .sleep_we(sleep_we), .sleep_wd(sleep_wd),
        .flag_clr(flag_clr), .rx_data(rx_data), .flag_rdrf(flag_rdrf),
        .flag_idle(flag_idle), .flag_ovr(flag_ovr), .flag_noise(flag_noise),
        .flag_ferr(flag_ferr), .sleep(sleep)
    );

    // {w9, stop, noisy, noise_pos[3:0], din[8:0], exp_data[8:0], exp_nf, exp_fe}
    localparam logic [26:0] VEC [7] = '{
        {1'b0, 1'b1, 1'b0, 4'd0, 9'h0A5, 9'h0A5, 1'b0, 1'b0},
        {1'b0, 1'b1, 1'b0, 4'd0, 9'h0FF, 9'h0FF, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 4'd0, 9'h1C3, 9'h1C3, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 4'd0, 9'h000, 9'h000, 1'b0, 1'b0},
        {1'b0, 1'b0, 1'b0, 4'd0, 9'h03C, 9'h03C, 1'b0, 1'b1},
        {1'b0, 1'b1, 1'b1, 4'd4, 9'h155, 9'h055, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b1, 4'd0, 9'h12A, 9'h12A, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b, input logic nz);
        @(negedge clk);
        rx_smp   = nz ? {b, b, ~b} : {b, b, b};
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
        rx_smp   = 3'b111;
        repeat (2) @(negedge clk);
    endtask

    task automatic send_ones(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0);
    endtask

    task automatic send_frame(input logic w9, input logic [8:0] d, input logic stop,
                              input logic nz, input int npos);
        int nb;
        nb = w9 ? 9 : 8;
        for (int i = 0; i < nb + 2; i++) begin
            logic b;
            if (i == 0)           b = 1'b0;
            else if (i == nb + 1) b = stop;
            else                  b = d[i-1];
            send_bit(b, nz && (i == npos));
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic write_sleep(input logic v);
        @(negedge clk); sleep_we = 1'b1; sleep_wd = v;
        @(negedge clk); sleep_we = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [4:0] flags();
        return {flag_rdrf, flag_idle, flag_ovr, flag_noise, flag_ferr};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 reset flags", 32'(flags()), 0);
        check("R4 reset sleep", 32'(sleep), 0);
        check("R1 reset data", 32'(rx_data), 0);
        rx_en = 1'b1;
        send_ones(12);

        // table walk: R1 framing, R2 majority/noise/framing error
        for (int v = 0; v < 7; v++) begin
            logic [26:0] e;
            e = VEC[v];
            word9 = e[26];
            pulse_clr();
            send_frame(e[26], e[19:11], e[25], e[24], int'(e[23:20]));
            check("R1 data", 32'(rx_data), 32'(e[10:2]));
            check("R1 rdrf", 32'(flag_rdrf), 1);
            check("R2 noise", 32'(flag_noise), 32'(e[1]));
            check("R2 ferr", 32'(flag_ferr), 32'(e[0]));
            check("R9 no ovr", 32'(flag_ovr), 0);
        end

        // R9 overrun, R10 idle flag, R11 clear
        word9 = 1'b0; wake_addr = 1'b0;
        pulse_clr();
        send_frame(0, 9'h011, 1, 0, 0);
        send_frame(0, 9'h022, 1, 0, 0);
        check("R9 ovr", 32'(flag_ovr), 1);
        check("R9 old data", 32'(rx_data), 32'h011);
        send_ones(8);
        check("R10 idle early", 32'(flag_idle), 0);
        send_ones(2);
        check("R10 idle", 32'(flag_idle), 1);
        pulse_clr();
        check("R11 clear", 32'(flags()), 0);

        // R5, R4, R6 idle-line wake, 8-bit
        send_frame(0, 9'h033, 0, 1, 2);
        check("R2 flags set", 32'(flags()), 32'b10011);
        write_sleep(1);
        check("R6 asleep", 32'(sleep), 1);
        check("R5 flags kept", 32'(flags()), 32'b10011);
        send_ones(7);
        send_frame(0, 9'h000, 1, 0, 0);
        check("R4 no ovr asleep", 32'(flags()), 32'b10011);
        check("R4 data kept", 32'(rx_data), 32'h033);
        send_ones(8);
        check("R6 still asleep at 9", 32'(sleep), 1);
        send_ones(1);
        check("R6 woke at 10", 32'(sleep), 0);
        check("R4 no idle on wake", 32'(flag_idle), 0);

        // R7 write ignored on idle line
        write_sleep(1);
        check("R7 ignored", 32'(sleep), 0);

        // R6 9-bit
        word9 = 1'b1;
        pulse_clr();
        send_frame(1, 9'h0F0, 1, 0, 0);
        write_sleep(1);
        check("R6 asleep 9b", 32'(sleep), 1);
        send_ones(10);
        check("R6 still asleep at 10", 32'(sleep), 1);
        send_ones(1);
        check("R6 woke at 11", 32'(sleep), 0);

        // R8 address-mark, 8-bit
        word9 = 1'b0; wake_addr = 1'b1;
        pulse_clr();
        write_sleep(1);
        check("R8 set on idle line", 32'(sleep), 1);
        send_frame(0, 9'h07F, 1, 0, 0);
        check("R8 dropped rdrf", 32'(flag_rdrf), 0);
        check("R8 dropped data", 32'(rx_data), 32'h0F0);
        check("R8 still asleep", 32'(sleep), 1);
        send_frame(0, 9'h085, 1, 0, 0);
        check("R8 woke", 32'(sleep), 0);
        check("R8 data", 32'(rx_data), 32'h085);
        check("R8 rdrf", 32'(flag_rdrf), 1);

        // R8 address-mark, 9-bit
        word9 = 1'b1;
        pulse_clr();
        write_sleep(1);
        send_frame(1, 9'h0FF, 1, 0, 0);
        check("R8 9b dropped", 32'(rx_data), 32'h085);
        check("R8 9b asleep", 32'(sleep), 1);
        check("R8 9b no flag", 32'(flags()), 0);
        send_frame(1, 9'h101, 1, 0, 0);
        check("R8 9b woke", 32'(sleep), 0);
        check("R8 9b data", 32'(rx_data), 32'h101);
        check("R8 9b rdrf", 32'(flag_rdrf), 1);

        // R3 disabled receiver
        @(negedge clk); rx_en = 1'b0;
        repeat (2) @(negedge clk);
        check("R3 flags low", 32'(flags()), 0);
        send_frame(1, 9'h1AA, 0, 1, 3);
        check("R3 stays low", 32'(flags()), 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule